// File: doc/BRIEF.md
# E1 Frame Alignment Monitor

This block watches a stream of E1 time-slot octets that an upstream framer has already located and labelled. Each accepted octet carries its time-slot number and the index of its frame within the 16-frame signalling multiframe. In time slot 0, even frames carry the 7-bit frame alignment word and odd frames carry a marker bit. Time slot 16 of frame 0 carries the 4-bit multiframe alignment word. The monitor checks each of these words against its expected value, captures the received fields, and gives a one-cycle error pulse for every word that fails.

A run counter tracks frame alignment words that are wrong in succession. When the second one arrives in a row, the monitor raises a persistent alarm. The first correct frame alignment word then clears both the run and the alarm. The odd frames between alignment words do not break a run. The block has no framing search and no CRC-4 processing. It only judges words that arrive at positions the upstream logic has already fixed.

Bits are numbered 1 to 8 within an octet. Bit 1 is the first bit on the line and sits at `oct_data[7]`. Bit 8 sits at `oct_data[0]`. Every output is registered, so the outputs show the result of an accepted octet one clock after it.

Top module: `e1_align_monitor`

## Requirements
- R1: While reset is asserted and after its release, `fas_word`, `nfas_mark`, `mfas_word`, all three error pulses and `align_alarm` are 0.
- R2: A valid octet in time slot 0 with an even frame index loads bits 2..8 (`oct_data[6:0]`) into `fas_word` one cycle later. Bit 1 (`oct_data[7]`) is ignored.
- R3: For such an octet, `fas_err_pulse` is high for exactly one cycle, in that same cycle, exactly when bits 2..8 differ from 0011011 (7'h1B).
- R4: A valid octet in time slot 0 with an odd frame index loads bit 2 (`oct_data[6]`) into `nfas_mark` one cycle later. `nfas_err_pulse` is high for that one cycle exactly when this bit is 0.
- R5: A valid octet in time slot 16 of frame 0 loads bits 1..4 (`oct_data[7:4]`) into `mfas_word` one cycle later. `mfas_err_pulse` is high for that one cycle exactly when the field is not 0000.
- R6: Octets in any other time slot, and time-slot-16 octets in frames 1..15, change no captured field and raise no pulse.
- R7: `align_alarm` rises in the same cycle as the `fas_err_pulse` of the second errored frame alignment word in a row. Odd frames and other slots between the two words do not break the run.
- R8: A correct frame alignment word resets the error run to zero and drops `align_alarm` one cycle after it is accepted. A single error that follows a correct word raises no alarm.
- R9: Once raised, `align_alarm` stays high through further errored alignment words and through every other octet, until a correct alignment word arrives.
- R10: While `oct_valid` is low, no captured field changes, no pulse is raised and the error run is unchanged, whatever `oct_data`, `ts_idx` and `frm_idx` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oct_valid | input | 1 | Octet strobe |
| oct_data | input | 8 | Received octet, bit 1 at index 7 |
| ts_idx | input | 5 | Time-slot number 0..31 |
| frm_idx | input | 4 | Frame number within the multiframe, 0..15 |
| fas_word | output | 7 | Last captured frame alignment field (bits 2..8) |
| nfas_mark | output | 1 | Last captured marker bit from an odd frame |
| mfas_word | output | 4 | Last captured multiframe alignment field |
| fas_err_pulse | output | 1 | One-cycle pulse: errored frame alignment word |
| nfas_err_pulse | output | 1 | One-cycle pulse: marker bit was 0 |
| mfas_err_pulse | output | 1 | One-cycle pulse: errored multiframe alignment word |
| align_alarm | output | 1 | Two consecutive frame alignment words in error |

## Verification
The per-word error pulse and the change of the alarm level can fall in the same cycle. The second bad alignment word raises both `fas_err_pulse` and `align_alarm` on one edge, and a good word drops the alarm while the pulse stays low. The bench provokes the raise by sending two bad alignment words with a good-marker odd frame between them. It then samples both outputs at the negative edge after the second word and expects both high together. An invalid bad word is also sent while a run of one is pending, and the alarm must stay low, which shows that the strobe gates the counting as well as the capture.

// File: rtl/e1am_pkg.sv
package e1am_pkg;

  localparam int OCT_W = 8;

  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_FAS  = 2'd1,
    SLOT_NFAS = 2'd2,
    SLOT_MFAS = 2'd3
  } slot_kind_e;

  // bits 2..8 of the octet, bit 1 being the MSB
  function automatic logic [6:0] fas_field(input logic [OCT_W-1:0] octet);
    return octet[6:0];
  endfunction

  // bit 2 of the octet
  function automatic logic marker_field(input logic [OCT_W-1:0] octet);
    return octet[OCT_W-2];
  endfunction

  // bits 1..4 of the octet
  function automatic logic [3:0] mfas_field(input logic [OCT_W-1:0] octet);
    return octet[OCT_W-1:OCT_W-4];
  endfunction

  // saturating increment of the error run
  function automatic int run_step(input int run, input int limit);
    if (run >= limit) return limit;
    return run + 1;
  endfunction

endpackage

// File: rtl/e1am_slot_decode.sv
module e1am_slot_decode
  import e1am_pkg::*;
#(
  parameter int TS_W    = 5,
  parameter int FRM_W   = 4,
  parameter int ALIGN_TS = 0,
  parameter int MFAS_TS = 16
) (
  input  logic             oct_valid,
  input  logic [TS_W-1:0]  ts_idx,
  input  logic [FRM_W-1:0] frm_idx,
  output slot_kind_e       kind
);

  localparam logic [TS_W-1:0]  TS_ALIGN = TS_W'(ALIGN_TS);
  localparam logic [TS_W-1:0]  TS_MF    = TS_W'(MFAS_TS);
  localparam logic [FRM_W-1:0] FRM_ZERO = '0;

  logic in_ts0;
  logic in_ts16;
  logic odd_frame;

  assign in_ts0    = (ts_idx == TS_ALIGN);
  assign in_ts16   = (ts_idx == TS_MF);
  assign odd_frame = frm_idx[0];

  always_comb begin
    kind = SLOT_NONE;
    if (oct_valid) begin
      if (in_ts0 && !odd_frame)             kind = SLOT_FAS;
      else if (in_ts0 && odd_frame)         kind = SLOT_NFAS;
      else if (in_ts16 && frm_idx == FRM_ZERO) kind = SLOT_MFAS;
    end
  end

endmodule

// File: rtl/e1am_ts0_check.sv
module e1am_ts0_check
  import e1am_pkg::*;
#(
  parameter logic [6:0] FAS_PAT   = 7'b0011011,
  parameter logic       NFAS_MARK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_kind_e       kind,
  input  logic [OCT_W-1:0] octet,
  output logic [6:0]       fas_word,
  output logic             nfas_mark,
  output logic             fas_err_pulse,
  output logic             nfas_err_pulse,
  output logic             fas_seen,
  output logic             fas_bad
);

  logic nfas_seen;
  logic nfas_bad;

  assign fas_seen  = (kind == SLOT_FAS);
  assign nfas_seen = (kind == SLOT_NFAS);
  assign fas_bad   = (fas_field(octet) != FAS_PAT);
  assign nfas_bad  = (marker_field(octet) != NFAS_MARK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fas_word       <= '0;
      nfas_mark      <= 1'b0;
      fas_err_pulse  <= 1'b0;
      nfas_err_pulse <= 1'b0;
    end else begin
      fas_err_pulse  <= fas_seen && fas_bad;
      nfas_err_pulse <= nfas_seen && nfas_bad;
      if (fas_seen)  fas_word  <= fas_field(octet);
      if (nfas_seen) nfas_mark <= marker_field(octet);
    end
  end

endmodule

// File: rtl/e1am_ts16_capture.sv
module e1am_ts16_capture
  import e1am_pkg::*;
#(
  parameter logic [3:0] MFAS_PAT = 4'b0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_kind_e       kind,
  input  logic [OCT_W-1:0] octet,
  output logic [3:0]       mfas_word,
  output logic             mfas_err_pulse
);

  logic mf_seen;
  logic mf_bad;

  assign mf_seen = (kind == SLOT_MFAS);
  assign mf_bad  = (mfas_field(octet) != MFAS_PAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mfas_word      <= '0;
      mfas_err_pulse <= 1'b0;
    end else begin
      mfas_err_pulse <= mf_seen && mf_bad;
      if (mf_seen) mfas_word <= mfas_field(octet);
    end
  end

endmodule

// File: rtl/e1am_run_alarm.sv
module e1am_run_alarm
  import e1am_pkg::*;
#(
  parameter int ALARM_THRESH = 2,
  localparam int RUN_W = $clog2(ALARM_THRESH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fas_seen,
  input  logic             fas_bad,
  output logic [RUN_W-1:0] err_run,
  output logic             align_alarm
);

  logic [RUN_W-1:0] run_next;
  logic             reach;

  always_comb begin
    run_next = RUN_W'(run_step(int'(err_run), ALARM_THRESH));
  end

  generate
    if (ALARM_THRESH <= 1) begin : g_single
      assign reach = 1'b1;
    end else begin : g_multi
      assign reach = (int'(run_next) >= ALARM_THRESH);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_run     <= '0;
      align_alarm <= 1'b0;
    end else if (fas_seen) begin
      if (fas_bad) begin
        err_run     <= run_next;
        align_alarm <= align_alarm || reach;
      end else begin
        err_run     <= '0;
        align_alarm <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/e1_align_monitor.sv
module e1_align_monitor
  import e1am_pkg::*;
#(
  parameter int         TS_W         = 5,
  parameter int         FRM_W        = 4,
  parameter int         MFAS_TS      = 16,
  parameter logic [6:0] FAS_PAT      = 7'b0011011,
  parameter logic       NFAS_MARK    = 1'b1,
  parameter logic [3:0] MFAS_PAT     = 4'b0000,
  parameter int         ALARM_THRESH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oct_valid,
  input  logic [7:0]       oct_data,
  input  logic [TS_W-1:0]  ts_idx,
  input  logic [FRM_W-1:0] frm_idx,
  output logic [6:0]       fas_word,
  output logic             nfas_mark,
  output logic [3:0]       mfas_word,
  output logic             fas_err_pulse,
  output logic             nfas_err_pulse,
  output logic             mfas_err_pulse,
  output logic             align_alarm
);

  localparam int RUN_W = $clog2(ALARM_THRESH + 1);

  slot_kind_e       kind;
  logic             fas_seen;
  logic             fas_bad;
  logic [RUN_W-1:0] err_run;

  e1am_slot_decode #(
    .TS_W(TS_W), .FRM_W(FRM_W), .ALIGN_TS(0), .MFAS_TS(MFAS_TS)
  ) u_dec (
    .oct_valid(oct_valid), .ts_idx(ts_idx), .frm_idx(frm_idx), .kind(kind)
  );

  e1am_ts0_check #(
    .FAS_PAT(FAS_PAT), .NFAS_MARK(NFAS_MARK)
  ) u_ts0 (
    .clk(clk), .rst_n(rst_n), .kind(kind), .octet(oct_data),
    .fas_word(fas_word), .nfas_mark(nfas_mark),
    .fas_err_pulse(fas_err_pulse), .nfas_err_pulse(nfas_err_pulse),
    .fas_seen(fas_seen), .fas_bad(fas_bad)
  );

  e1am_ts16_capture #(
    .MFAS_PAT(MFAS_PAT)
  ) u_ts16 (
    .clk(clk), .rst_n(rst_n), .kind(kind), .octet(oct_data),
    .mfas_word(mfas_word), .mfas_err_pulse(mfas_err_pulse)
  );

  e1am_run_alarm #(
    .ALARM_THRESH(ALARM_THRESH)
  ) u_run (
    .clk(clk), .rst_n(rst_n), .fas_seen(fas_seen), .fas_bad(fas_bad),
    .err_run(err_run), .align_alarm(align_alarm)
  );

endmodule

// File: rtl/e1am_checker.sv
module e1am_checker #(
  parameter int TS_W         = 5,
  parameter int FRM_W        = 4,
  parameter int MFAS_TS      = 16,
  parameter int ALARM_THRESH = 2,
  localparam int RUN_W = $clog2(ALARM_THRESH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oct_valid,
  input logic [TS_W-1:0]  ts_idx,
  input logic [FRM_W-1:0] frm_idx,
  input logic [6:0]       fas_word,
  input logic             nfas_mark,
  input logic [3:0]       mfas_word,
  input logic             fas_err_pulse,
  input logic             nfas_err_pulse,
  input logic             mfas_err_pulse,
  input logic             align_alarm,
  input logic             fas_seen,
  input logic             fas_bad,
  input logic [RUN_W-1:0] err_run
);

  AST_FAS_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    fas_err_pulse |-> $past(oct_valid && ts_idx == '0 && !frm_idx[0])); // R3
  AST_NFAS_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    nfas_err_pulse |-> $past(oct_valid && ts_idx == '0 && frm_idx[0])); // R4
  AST_MFAS_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    mfas_err_pulse |-> $past(oct_valid && ts_idx == TS_W'(MFAS_TS) && frm_idx == '0)); // R5
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fas_err_pulse, nfas_err_pulse, mfas_err_pulse}) <= 1); // R6
  AST_ALARM_RISE_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(align_alarm) |-> fas_err_pulse); // R7
  AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fas_seen && !fas_bad) |=> (!align_alarm && err_run == '0)); // R8
  AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (align_alarm && !(fas_seen && !fas_bad)) |=> align_alarm); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !oct_valid |=> ($stable(fas_word) && $stable(nfas_mark) && $stable(mfas_word)
                    && !fas_err_pulse && !nfas_err_pulse && !mfas_err_pulse)); // R10
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(err_run) <= ALARM_THRESH); // R7

endmodule

bind e1_align_monitor e1am_checker #(
  .TS_W(TS_W), .FRM_W(FRM_W), .MFAS_TS(MFAS_TS), .ALARM_THRESH(ALARM_THRESH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .oct_valid(oct_valid), .ts_idx(ts_idx),
  .frm_idx(frm_idx), .fas_word(fas_word), .nfas_mark(nfas_mark),
  .mfas_word(mfas_word), .fas_err_pulse(fas_err_pulse),
  .nfas_err_pulse(nfas_err_pulse), .mfas_err_pulse(mfas_err_pulse),
  .align_alarm(align_alarm), .fas_seen(fas_seen), .fas_bad(fas_bad),
  .err_run(err_run)
);

// File: tb/e1_align_monitor_test.sv
`timescale 1ns/1ps
module e1_align_monitor_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oct_valid = 1'b0;
  logic [7:0] oct_data = '0;
  logic [4:0] ts_idx = '0;
  logic [3:0] frm_idx = '0;
  logic [6:0] fas_word;
  logic       nfas_mark;
  logic [3:0] mfas_word;
  logic       fas_err_pulse;
  logic       nfas_err_pulse;
  logic       mfas_err_pulse;
  logic       align_alarm;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  e1_align_monitor uut (
    .clk(clk), .rst_n(rst_n), .oct_valid(oct_valid), .oct_data(oct_data),
    .ts_idx(ts_idx), .frm_idx(frm_idx), .fas_word(fas_word),
    .nfas_mark(nfas_mark), .mfas_word(mfas_word),
    .fas_err_pulse(fas_err_pulse), .nfas_err_pulse(nfas_err_pulse),
    .mfas_err_pulse(mfas_err_pulse), .align_alarm(align_alarm)
  );

  // bench view of the expected words
  function automatic logic fas_is_bad(input logic [7:0] d);
    return d[6:0] != 7'h1B;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp,
                       input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one octet at a falling edge, return at the next falling edge
  task automatic push(input logic v, input logic [7:0] d,
                      input logic [4:0] ts, input logic [3:0] fr);
    oct_valid = v; oct_data = d; ts_idx = ts; frm_idx = fr;
    @(posedge clk);
    @(negedge clk);
    oct_valid = 1'b0;
  endtask

  task automatic t_reset();
    check({1'b0, fas_word}, 8'h00, "R1", "fas_word");
    check({7'b0, nfas_mark}, 8'h00, "R1", "nfas_mark");
    check({4'b0, mfas_word}, 8'h00, "R1", "mfas_word");
    check({5'b0, fas_err_pulse, nfas_err_pulse, mfas_err_pulse}, 8'h00, "R1", "pulses");
    check({7'b0, align_alarm}, 8'h00, "R1", "align_alarm");
  endtask

  task automatic t_fas_good();
    push(1'b1, 8'h9B, 5'd0, 4'd2);
    check({1'b0, fas_word}, 8'h1B, "R2", "fas_word bit1 ignored");
    check({7'b0, fas_err_pulse}, {7'b0, fas_is_bad(8'h9B)}, "R3", "good fas pulse");
  endtask

  task automatic t_fas_single_err();
    push(1'b1, 8'h1A, 5'd0, 4'd4);
    check({1'b0, fas_word}, 8'h1A, "R2", "fas_word bad");
    check({7'b0, fas_err_pulse}, 8'h01, "R3", "bad fas pulse");
    check({7'b0, align_alarm}, 8'h00, "R8", "single error no alarm");
    push(1'b0, 8'h00, 5'd1, 4'd4);
    check({7'b0, fas_err_pulse}, 8'h00, "R3", "pulse lasts one cycle");
  endtask

  // second bad word after an odd frame: pulse and alarm in one cycle
  task automatic t_nfas_and_alarm();
    push(1'b1, 8'h40, 5'd0, 4'd5);
    check({7'b0, nfas_mark}, 8'h01, "R4", "marker one");
    check({7'b0, nfas_err_pulse}, 8'h00, "R4", "marker ok no pulse");
    push(1'b1, 8'hBF, 5'd0, 4'd7);
    check({7'b0, nfas_mark}, 8'h00, "R4", "marker zero");
    check({7'b0, nfas_err_pulse}, 8'h01, "R4", "marker bad pulse");
    check({7'b0, align_alarm}, 8'h00, "R7", "odd frame not counted");
    push(1'b1, 8'h7F, 5'd0, 4'd8);
    check({6'b0, fas_err_pulse, align_alarm}, 8'h03, "R7", "pulse and alarm together");
  endtask

  task automatic t_alarm_hold();
    push(1'b1, 8'h00, 5'd0, 4'd10);
    check({7'b0, align_alarm}, 8'h01, "R9", "alarm on further error");
    push(1'b1, 8'h55, 5'd5, 4'd11);
    check({7'b0, align_alarm}, 8'h01, "R9", "alarm on other slot");
    push(1'b1, 8'h40, 5'd0, 4'd11);
    check({7'b0, align_alarm}, 8'h01, "R9", "alarm on odd frame");
  endtask

  task automatic t_alarm_clear();
    push(1'b1, 8'h1B, 5'd0, 4'd12);
    check({6'b0, fas_err_pulse, align_alarm}, 8'h00, "R8", "good word clears");
    push(1'b1, 8'h3B, 5'd0, 4'd14);
    check({6'b0, fas_err_pulse, align_alarm}, 8'h02, "R8", "run restarted");
  endtask

  task automatic t_mfas();
    push(1'b1, 8'h0B, 5'd16, 4'd0);
    check({4'b0, mfas_word}, 8'h00, "R5", "mfas good");
    check({7'b0, mfas_err_pulse}, 8'h00, "R5", "mfas good no pulse");
    push(1'b1, 8'h5F, 5'd16, 4'd0);
    check({4'b0, mfas_word}, 8'h05, "R5", "mfas bad value");
    check({7'b0, mfas_err_pulse}, 8'h01, "R5", "mfas bad pulse");
    push(1'b1, 8'hA0, 5'd16, 4'd3);
    check({4'b0, mfas_word}, 8'h05, "R6", "ts16 other frame held");
    check({5'b0, fas_err_pulse, nfas_err_pulse, mfas_err_pulse}, 8'h00, "R6", "ts16 other frame pulses");
  endtask

  task automatic t_other_slot();
    push(1'b1, 8'h00, 5'd3, 4'd0);
    check({1'b0, fas_word}, 8'h3B, "R6", "other slot fas held");
    check({7'b0, nfas_mark}, 8'h01, "R6", "other slot marker held");
    check({5'b0, fas_err_pulse, nfas_err_pulse, mfas_err_pulse}, 8'h00, "R6", "other slot pulses");
  endtask

  // run is one here; an invalid bad word must not make it two
  task automatic t_invalid();
    push(1'b0, 8'h00, 5'd0, 4'd0);
    check({1'b0, fas_word}, 8'h3B, "R10", "invalid fas held");
    check({7'b0, fas_err_pulse}, 8'h00, "R10", "invalid no pulse");
    check({7'b0, align_alarm}, 8'h00, "R10", "invalid not counted");
    push(1'b0, 8'hF0, 5'd16, 4'd0);
    check({4'b0, mfas_word}, 8'h05, "R10", "invalid mfas held");
    check({7'b0, mfas_err_pulse}, 8'h00, "R10", "invalid mfas no pulse");
    push(1'b1, 8'h1B, 5'd0, 4'd0);
    push(1'b1, 8'h00, 5'd0, 4'd2);
    check({7'b0, align_alarm}, 8'h00, "R8", "one error after good");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fas_good();
    t_fas_single_err();
    t_nfas_and_alarm();
    t_alarm_hold();
    t_alarm_clear();
    t_mfas();
    t_other_slot();
    t_invalid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    failures++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule